// File: doc/BRIEF.md
# PHY Link and Autonegotiation Controller

This block pairs a small Ethernet PHY register file with the link-state logic on the MAC side. Software reaches both through one synchronous register bus. A select bit picks one of two address spaces. The first is a 32-entry PHY space, of which the lowest `PHY_IMPL` entries are real storage. The second is a small MAC space that holds interrupt status, interrupt mask, the adapter link bit and a sticky link-change flag.

An external `link_present` level is synchronised and edge-detected. A falling edge is a link-down event. A rising edge is a link-up event. A link-up event is held back by a negotiation timer of `NEG_CYCLES` clocks when autonegotiation is enabled in the PHY control register but not yet marked complete in the PHY status register. Each event updates the PHY status bits, the adapter link bit, the change flag and the interrupt status in the same clock.

The controller is a four-state machine:
- `ST_INIT` waits for the synchroniser to fill after reset.
- `ST_DOWN` means no link.
- `ST_NEGOT` means the timer is running.
- `ST_UP` means the link is up.

Its transitions are:
- init-to-up when the link is present at the end of init.
- init-to-down, with quiet clears, when it is absent.
- down-to-negotiate on a rising edge with negotiation pending.
- down-to-up on a rising edge otherwise.
- negotiate-to-up when the timer expires.
- negotiate-to-down on a falling edge.
- up-to-down on a falling edge.

Top module: `phy_link_ctrl`

## Requirements
- R1: After reset, the PHY registers read as follows, and all other PHY entries read 0:
  - index 0 (control) = 0x1100: bit 12 enables autonegotiation, bit 8 selects full duplex.
  - index 1 (status) = 0x002C: bit 5 is negotiation-complete, bit 3 is negotiation ability, bit 2 is link status. The link status and negotiation-complete bits are then cleared per R10 when the link is absent at reset.
  - index 4 (advertise) = 0x03E0.
  - index 5 (partner) = 0x03E0.
- R2: A link-down event clears status bits 2 and 5 and partner bit 14 (acknowledge). It also clears the adapter link bit (MAC index 2, bit 0), sets the change flag (MAC index 3, bit 0) and sets the MII-event interrupt status (MAC index 0, bit 0).
- R3: On a link-up event with control bit 12 set and status bit 5 clear, the link stays down. The link-up actions happen exactly NEG_CYCLES+3 rising edges after `link_present` rises, and not one edge earlier.
- R4: On timer expiry, partner bit 14 and status bit 5 are set together with the link-up actions. The link-up actions are: set status bit 2, set the adapter link bit, set the change flag, and set the interrupt status.
- R5: If the link falls during negotiation, the timer is cancelled and no link-up actions follow.
- R6: When control bit 12 is clear, or status bit 5 is already set, a link-up event performs the link-up actions at once.
- R7: `irq` is high exactly when interrupt status bit 0 and mask bit 0 (MAC index 1) are both set.
- R8: A write to MAC index 0 or 3 clears the bits written as 1 and leaves bits written as 0 unchanged.
- R9: PHY writes at indices below PHY_IMPL store all 16 bits. At indices from PHY_IMPL up to 31, writes are ignored and reads return 0. Unused MAC indices read 0.
- R10: Reset cancels a running negotiation timer. The adapter link bit resets to 0. If the link is absent at reset, status bits 2 and 5 and partner bit 14 are cleared without setting the change flag or the interrupt status.
- R11: A link edge is synchronised and acts on registers at the third rising clock edge after the input changes, not at the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_present | input | 1 | Asynchronous link level from the medium |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_phy | input | 1 | 1 = PHY space, 0 = MAC space |
| bus_addr | input | 5 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Masked interrupt request |

## Verification
The link input is driven through several sequences:
- A down edge and an up edge with negotiation pending. The bench samples one edge before and exactly at the expected expiry, which separates a correct timer length from an off-by-one.
- A drop in the middle of negotiation. This shows whether the timer is truly cancelled.
- Up edges with negotiation disabled and with completion already recorded. These separate the immediate path from the timed one.

Resets are applied with the link present during negotiation and with the link absent. Together they tell quiet reset clears apart from real link events. Write-1-to-clear writes with zero and one data, plus out-of-range PHY indices, complete the register checks.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_DOWN,
        ST_NEGOT,
        ST_UP
    } link_state_e;

    typedef struct packed {
        logic quiet_down;
        logic down;
        logic up;
        logic an_done;
        logic tmr_start;
        logic tmr_cancel;
    } link_act_t;

    localparam int IDX_CTRL   = 0;
    localparam int IDX_STAT   = 1;
    localparam int IDX_ADV    = 4;
    localparam int IDX_PART   = 5;

    localparam logic [15:0] CTRL_ANEN  = 16'h1000;
    localparam logic [15:0] CTRL_FDX   = 16'h0100;
    localparam logic [15:0] STAT_LINK  = 16'h0004;
    localparam logic [15:0] STAT_ABIL  = 16'h0008;
    localparam logic [15:0] STAT_ANC   = 16'h0020;
    localparam logic [15:0] ADV_ABIL   = 16'h03E0;
    localparam logic [15:0] PART_ACK   = 16'h4000;

    localparam logic [4:0] MAC_IRQ_STAT = 5'd0;
    localparam logic [4:0] MAC_IRQ_MASK = 5'd1;
    localparam logic [4:0] MAC_ADAPTER  = 5'd2;
    localparam logic [4:0] MAC_MII_STAT = 5'd3;

    function automatic logic [15:0] phy_rst_val(input int idx);
        case (idx)
            IDX_CTRL: return CTRL_ANEN | CTRL_FDX;
            IDX_STAT: return STAT_ABIL | STAT_ANC | STAT_LINK;
            IDX_ADV:  return ADV_ABIL;
            IDX_PART: return ADV_ABIL;
            default:  return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/plc_edge_sync.sv
module plc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;
    assign fall  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/plc_neg_timer.sv
module plc_neg_timer #(
    parameter int CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic done,
    output logic running
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (cancel) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CW'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done    = run_q && (cnt_q == '0);
    assign running = run_q;
endmodule

// File: rtl/plc_link_fsm.sv
module plc_link_fsm
    import plc_pkg::*;
#(
    parameter int INIT_WAIT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        level,
    input  logic        rise,
    input  logic        fall,
    input  logic        an_en,
    input  logic        an_cmp,
    input  logic        tmr_done,
    output link_state_e state,
    output link_act_t   act
);
    localparam int IW = $clog2(INIT_WAIT + 1);

    link_state_e state_q, state_d;
    logic [IW-1:0] init_cnt_q;
    logic          init_end;

    assign init_end = (init_cnt_q == IW'(INIT_WAIT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_cnt_q <= '0;
        end else if (state_q == ST_INIT && !init_end) begin
            init_cnt_q <= init_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: begin
                if (init_end) state_d = level ? ST_UP : ST_DOWN;
            end
            ST_DOWN: begin
                if (rise) state_d = (an_en && !an_cmp) ? ST_NEGOT : ST_UP;
            end
            ST_NEGOT: begin
                if (fall)          state_d = ST_DOWN;
                else if (tmr_done) state_d = ST_UP;
            end
            ST_UP: begin
                if (fall) state_d = ST_DOWN;
            end
        endcase
    end

    always_comb begin
        act = '0;
        unique case (state_q)
            ST_INIT: begin
                act.quiet_down = init_end && !level;
            end
            ST_DOWN: begin
                if (rise) begin
                    act.tmr_start = an_en && !an_cmp;
                    act.up        = !(an_en && !an_cmp);
                end
            end
            ST_NEGOT: begin
                if (fall) begin
                    act.down       = 1'b1;
                    act.tmr_cancel = 1'b1;
                end else if (tmr_done) begin
                    act.an_done = 1'b1;
                    act.up      = 1'b1;
                end
            end
            ST_UP: begin
                act.down = fall;
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/phy_link_ctrl.sv
module phy_link_ctrl
    import plc_pkg::*;
#(
    parameter int NEG_CYCLES  = 50_000_000,
    parameter int SYNC_STAGES = 2,
    parameter int PHY_IMPL    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_present,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic        bus_phy,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq
);
    localparam int INIT_WAIT = SYNC_STAGES + 1;

    logic        lvl, rise, fall;
    logic        tmr_done, tmr_running;
    link_state_e state_q;
    link_act_t   act;

    logic [15:0] phy_q [PHY_IMPL];
    logic [15:0] phy_d [PHY_IMPL];
    logic        irq_stat_q, irq_mask_q, adapter_link_q, mii_chg_q;
    logic        irq_stat_d, irq_mask_d, adapter_link_d, mii_chg_d;
    logic        phy_wr, mac_wr, ev;
    logic        unused_wdata;

    assign unused_wdata = ^bus_wdata[15:1];

    plc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (link_present),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    plc_neg_timer #(.CYCLES(NEG_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (act.tmr_start),
        .cancel  (act.tmr_cancel),
        .done    (tmr_done),
        .running (tmr_running)
    );

    plc_link_fsm #(.INIT_WAIT(INIT_WAIT)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lvl),
        .rise     (rise),
        .fall     (fall),
        .an_en    ((phy_q[IDX_CTRL] & CTRL_ANEN) != 16'h0),
        .an_cmp   ((phy_q[IDX_STAT] & STAT_ANC) != 16'h0),
        .tmr_done (tmr_done),
        .state    (state_q),
        .act      (act)
    );

    assign phy_wr = bus_en && bus_we && bus_phy;
    assign mac_wr = bus_en && bus_we && !bus_phy;
    assign ev     = act.up || act.down;

    always_comb begin
        for (int i = 0; i < PHY_IMPL; i++) begin
            phy_d[i] = phy_q[i];
            if (phy_wr && bus_addr == 5'(i)) phy_d[i] = bus_wdata;
        end
        if (act.down || act.quiet_down) begin
            phy_d[IDX_STAT] = phy_d[IDX_STAT] & ~(STAT_LINK | STAT_ANC);
            phy_d[IDX_PART] = phy_d[IDX_PART] & ~PART_ACK;
        end
        if (act.an_done) begin
            phy_d[IDX_STAT] = phy_d[IDX_STAT] | STAT_ANC;
            phy_d[IDX_PART] = phy_d[IDX_PART] | PART_ACK;
        end
        if (act.up) begin
            phy_d[IDX_STAT] = phy_d[IDX_STAT] | STAT_LINK;
        end
    end

    generate
        for (genvar g = 0; g < PHY_IMPL; g++) begin : g_phy
            always_ff @(posedge clk) begin
                if (!rst_n) phy_q[g] <= phy_rst_val(g);
                else        phy_q[g] <= phy_d[g];
            end
        end
    endgenerate

    always_comb begin
        irq_stat_d = irq_stat_q;
        if (mac_wr && bus_addr == MAC_IRQ_STAT && bus_wdata[0]) irq_stat_d = 1'b0;
        if (ev) irq_stat_d = 1'b1;

        mii_chg_d = mii_chg_q;
        if (mac_wr && bus_addr == MAC_MII_STAT && bus_wdata[0]) mii_chg_d = 1'b0;
        if (ev) mii_chg_d = 1'b1;

        irq_mask_d = irq_mask_q;
        if (mac_wr && bus_addr == MAC_IRQ_MASK) irq_mask_d = bus_wdata[0];

        adapter_link_d = adapter_link_q;
        if (act.down || act.quiet_down) adapter_link_d = 1'b0;
        if (act.up) adapter_link_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_stat_q     <= 1'b0;
            irq_mask_q     <= 1'b0;
            adapter_link_q <= 1'b0;
            mii_chg_q      <= 1'b0;
        end else begin
            irq_stat_q     <= irq_stat_d;
            irq_mask_q     <= irq_mask_d;
            adapter_link_q <= adapter_link_d;
            mii_chg_q      <= mii_chg_d;
        end
    end

    always_comb begin
        bus_rdata = 16'h0000;
        if (bus_en && !bus_we) begin
            if (bus_phy) begin
                for (int i = 0; i < PHY_IMPL; i++) begin
                    if (bus_addr == 5'(i)) bus_rdata = phy_q[i];
                end
            end else begin
                unique case (bus_addr)
                    MAC_IRQ_STAT: bus_rdata = {15'h0, irq_stat_q};
                    MAC_IRQ_MASK: bus_rdata = {15'h0, irq_mask_q};
                    MAC_ADAPTER:  bus_rdata = {15'h0, adapter_link_q};
                    MAC_MII_STAT: bus_rdata = {15'h0, mii_chg_q};
                    default:      bus_rdata = 16'h0000;
                endcase
            end
        end
    end

    assign irq = irq_stat_q & irq_mask_q;
endmodule

// File: rtl/plc_checker.sv
module plc_checker
    import plc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input link_state_e state,
    input logic        act_up,
    input logic        act_down,
    input logic        tmr_running,
    input logic        adapter_link,
    input logic        mii_chg,
    input logic        irq_stat,
    input logic        irq,
    input logic        mac_wr
);
    // R2: a link-down event leaves the link bit low and both flags set
    a_r2_down_flags: assert property (@(posedge clk) disable iff (!rst_n)
        act_down |=> (!adapter_link && mii_chg && irq_stat));

    // R4: a link-up action raises the adapter link bit and the change flag
    a_r4_up_sets_link: assert property (@(posedge clk) disable iff (!rst_n)
        act_up |=> (adapter_link && mii_chg));

    // R3: while negotiating the adapter link bit stays low
    a_r3_hold_while_negot: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEGOT) |-> !adapter_link);

    // R5: with the link down no negotiation timer runs
    a_r5_timer_idle_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN) |-> !tmr_running);

    // R7: irq only rises after a link event or a MAC register write
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(act_up || act_down || mac_wr));
endmodule

bind phy_link_ctrl plc_checker i_plc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state_q),
    .act_up       (act.up),
    .act_down     (act.down),
    .tmr_running  (tmr_running),
    .adapter_link (adapter_link_q),
    .mii_chg      (mii_chg_q),
    .irq_stat     (irq_stat_q),
    .irq          (irq),
    .mac_wr       (mac_wr)
);

// File: tb/test_phy_link_ctrl.sv
`timescale 1ns/1ps
module test_phy_link_ctrl;
    localparam int N = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_present = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_phy = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    phy_link_ctrl #(.NEG_CYCLES(N), .SYNC_STAGES(2), .PHY_IMPL(8)) i_phy_link_ctrl (
        .clk(clk), .rst_n(rst_n), .link_present(link_present),
        .bus_en(bus_en), .bus_we(bus_we), .bus_phy(bus_phy),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic rd(input logic phy, input logic [4:0] a, output logic [15:0] v);
        bus_en = 1'b1; bus_we = 1'b0; bus_phy = phy; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic phy, input logic [4:0] a,
                          input logic [15:0] exp);
        logic [15:0] v;
        rd(phy, a, v);
        chk(req, v, exp);
    endtask

    task automatic wr(input logic phy, input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_phy = phy; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_present = v;
    endtask

    task automatic wait_edges(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_edges(10);
    endtask

    task automatic clear_flags();
        wr(1'b0, 5'd3, 16'h0001);
        wr(1'b0, 5'd0, 16'h0001);
    endtask

    task automatic t_reset_present();
        do_reset();
        chk_rd("R1 ctrl", 1'b1, 5'd0, 16'h1100);
        chk_rd("R1 status", 1'b1, 5'd1, 16'h002C);
        chk_rd("R1 advertise", 1'b1, 5'd4, 16'h03E0);
        chk_rd("R1 partner", 1'b1, 5'd5, 16'h03E0);
        chk_rd("R1 other", 1'b1, 5'd2, 16'h0000);
        chk_rd("R1 other7", 1'b1, 5'd7, 16'h0000);
        chk_rd("R10 adapter", 1'b0, 5'd2, 16'h0000);
        chk_rd("R1 change", 1'b0, 5'd3, 16'h0000);
        chk("R7 irq reset", {15'h0, irq}, 16'h0000);
    endtask

    task automatic t_link_down();
        set_link(1'b0);
        wait_edges(2);
        chk_rd("R11 not yet", 1'b0, 5'd3, 16'h0000);
        wait_edges(1);
        chk_rd("R11 change", 1'b0, 5'd3, 16'h0001);
        chk_rd("R2 status", 1'b1, 5'd1, 16'h0008);
        chk_rd("R2 partner", 1'b1, 5'd5, 16'h03E0);
        chk_rd("R2 adapter", 1'b0, 5'd2, 16'h0000);
        chk_rd("R2 irqstat", 1'b0, 5'd0, 16'h0001);
        chk("R7 masked", {15'h0, irq}, 16'h0000);
    endtask

    task automatic t_irq_w1c();
        wr(1'b0, 5'd1, 16'h0001);
        chk("R7 unmasked", {15'h0, irq}, 16'h0001);
        wr(1'b0, 5'd3, 16'h0000);
        chk_rd("R8 zero write", 1'b0, 5'd3, 16'h0001);
        wr(1'b0, 5'd3, 16'h0001);
        chk_rd("R8 clear change", 1'b0, 5'd3, 16'h0000);
        chk("R7 irq holds", {15'h0, irq}, 16'h0001);
        wr(1'b0, 5'd0, 16'h0000);
        chk_rd("R8 irq zero write", 1'b0, 5'd0, 16'h0001);
        wr(1'b0, 5'd0, 16'h0001);
        chk("R8 irq cleared", {15'h0, irq}, 16'h0000);
    endtask

    task automatic t_negotiate();
        set_link(1'b1);
        wait_edges(N + 2);
        chk_rd("R3 early", 1'b0, 5'd2, 16'h0000);
        chk_rd("R3 early status", 1'b1, 5'd1, 16'h0008);
        chk("R3 no irq", {15'h0, irq}, 16'h0000);
        wait_edges(1);
        chk_rd("R4 adapter", 1'b0, 5'd2, 16'h0001);
        chk_rd("R4 status", 1'b1, 5'd1, 16'h002C);
        chk_rd("R4 partner ack", 1'b1, 5'd5, 16'h43E0);
        chk_rd("R4 change", 1'b0, 5'd3, 16'h0001);
        chk("R4 irq", {15'h0, irq}, 16'h0001);
        clear_flags();
    endtask

    task automatic t_drop_mid();
        set_link(1'b0);
        wait_edges(5);
        clear_flags();
        set_link(1'b1);
        wait_edges(N / 2);
        set_link(1'b0);
        wait_edges(N + 20);
        chk_rd("R5 adapter", 1'b0, 5'd2, 16'h0000);
        chk_rd("R5 status", 1'b1, 5'd1, 16'h0008);
        chk_rd("R5 partner", 1'b1, 5'd5, 16'h03E0);
        chk_rd("R5 change", 1'b0, 5'd3, 16'h0001);
        clear_flags();
        wait_edges(N);
        chk_rd("R5 no late up", 1'b0, 5'd3, 16'h0000);
    endtask

    task automatic t_an_off();
        wr(1'b1, 5'd0, 16'h0100);
        set_link(1'b1);
        wait_edges(3);
        chk_rd("R6 off adapter", 1'b0, 5'd2, 16'h0001);
        chk_rd("R6 off status", 1'b1, 5'd1, 16'h000C);
        chk_rd("R6 off change", 1'b0, 5'd3, 16'h0001);
        set_link(1'b0);
        wait_edges(5);
        clear_flags();
    endtask

    task automatic t_an_done_already();
        wr(1'b1, 5'd0, 16'h1100);
        wr(1'b1, 5'd1, 16'h0028);
        set_link(1'b1);
        wait_edges(3);
        chk_rd("R6 cmp adapter", 1'b0, 5'd2, 16'h0001);
        chk_rd("R6 cmp status", 1'b1, 5'd1, 16'h002C);
        clear_flags();
    endtask

    task automatic t_phy_range();
        wr(1'b1, 5'd3, 16'hABCD);
        chk_rd("R9 stored", 1'b1, 5'd3, 16'hABCD);
        wr(1'b1, 5'd12, 16'hFFFF);
        chk_rd("R9 ignored", 1'b1, 5'd12, 16'h0000);
        chk_rd("R9 top index", 1'b1, 5'd31, 16'h0000);
        chk_rd("R9 mac unused", 1'b0, 5'd7, 16'h0000);
        chk_rd("R9 neighbour", 1'b1, 5'd3, 16'hABCD);
    endtask

    task automatic t_reset_mid_negot();
        set_link(1'b0);
        wait_edges(5);
        set_link(1'b1);
        wait_edges(50);
        do_reset();
        chk_rd("R10 ctrl", 1'b1, 5'd0, 16'h1100);
        chk_rd("R10 status", 1'b1, 5'd1, 16'h002C);
        wait_edges(N + 20);
        chk_rd("R10 no pending", 1'b0, 5'd2, 16'h0000);
        chk_rd("R10 no change", 1'b0, 5'd3, 16'h0000);
    endtask

    task automatic t_reset_absent();
        link_present = 1'b0;
        do_reset();
        chk_rd("R10 absent status", 1'b1, 5'd1, 16'h0008);
        chk_rd("R10 absent partner", 1'b1, 5'd5, 16'h03E0);
        chk_rd("R10 absent ctrl", 1'b1, 5'd0, 16'h1100);
        chk_rd("R10 quiet change", 1'b0, 5'd3, 16'h0000);
        chk_rd("R10 quiet irqstat", 1'b0, 5'd0, 16'h0000);
        set_link(1'b1);
        wait_edges(N + 3);
        chk_rd("R3 after reset up", 1'b0, 5'd2, 16'h0001);
    endtask

    initial begin
        t_reset_present();
        t_link_down();
        t_irq_w1c();
        t_negotiate();
        t_drop_mid();
        t_an_off();
        t_an_done_already();
        t_phy_range();
        t_reset_mid_negot();
        t_reset_absent();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule